// File: doc/BRIEF.md
# Serial Readback CRC-16 Generator

This block computes a 16-bit cyclic redundancy check over a stream that arrives one bit per clock. Each bit offered with the valid input is folded into a bit-serial shift register with the generator polynomial x^16 + x^15 + x^2 + 1. The same bit is passed on to the serial output one register stage later. A marker on the final bit ends the stream. The block then appends its own 16-bit checksum to the outgoing stream on the same serial output, most significant bit first.

While the checksum is being sent, the block ignores all inputs. When the sixteenth checksum bit leaves, a one-cycle done pulse is raised and the register is left at zero, ready for the next stream. A parallel copy of the finished checksum is held on its own output until the next stream finishes.

The register starts from zero, with no reflection and no final inversion. A stream followed by its own checksum therefore leaves a zero remainder when it is run through the generator again.

Top module: `serialCrcGen`

## Requirements
- R1: After reset, serOut, outValid and done are 0 and crcOut is 16'h0000.
- R2: When the bit marked by lastFrame is accepted, crcOut takes the value of the bit-serial register at that point. The register starts at zero and, for each accepted bit d, becomes (reg << 1) XOR (16'h8005 if d XOR reg[15] is 1, else 0). Bits are taken in arrival order, with no reflection and no final XOR.
- R3: A bit accepted with serValid high appears on serOut with outValid high exactly one cycle later. In a cycle with no accepted bit and no checksum bit to send, outValid and serOut are both 0 one cycle later.
- R4: On the 16 cycles that follow the output of the last data bit, outValid is 1 and serOut carries the checksum, bit 15 first and bit 0 last.
- R5: During those 16 checksum cycles, serIn, serValid and lastFrame have no effect on serOut, outValid, done or crcOut, nor on the checksum of the next stream.
- R6: done is high for exactly one cycle, in the same cycle that checksum bit 0 is on serOut.
- R7: After each checksum has been sent, the register is zero again, so the same data stream gives the same checksum every time.
- R8: crcOut changes only when a last-marked bit is accepted. Otherwise it holds its value.
- R9: When the complete outgoing stream (data followed by checksum) is fed back in as a new stream, the resulting checksum is 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| serIn | input | 1 | Serial data bit |
| serValid | input | 1 | serIn carries a stream bit this cycle |
| lastFrame | input | 1 | Marks the accepted bit as the final bit of the stream |
| serOut | output | 1 | Delayed data bits, then the checksum, MSB first |
| outValid | output | 1 | serOut carries a stream or checksum bit |
| done | output | 1 | One-cycle pulse with the last checksum bit |
| crcOut | output | 16 | Checksum of the latest completed stream |

## Verification
Every result is due one rising edge after the edge that accepts the stimulus. The echoed data bit and its valid flag appear one edge later. crcOut updates on the edge that accepts the last-marked bit. The checksum bits appear on the 16 edges after that, with done on the sixteenth. The bench drives inputs 1 ns after an edge and steps a behavioural model once per edge. It compares every output 1 ns after each rising edge, so each output is sampled in the cycle the model says it changes. Beyond random streams, the bench runs several targeted cases:
- a stream with one bit flipped;
- a one-bit stream;
- a stream whose checksum window is filled with random valid inputs;
- a replay of the captured output stream, which must leave a zero remainder.

// File: rtl/serialCrcPkg.sv
package serialCrcPkg;
  localparam int CRC_W = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h8005;

  typedef enum logic {
    ST_DATA  = 1'b0,
    ST_SHIFT = 1'b1
  } crcState_e;

  typedef struct packed {
    logic absorb;    // fold serIn into the register and echo it
    logic capture;   // latch the finished checksum to crcOut
    logic shiftOut;  // send one checksum bit
    logic finalBit;  // this checksum bit is bit 0
  } crcStrobe_t;
endpackage

// File: rtl/serialCrcCtrl.sv
module serialCrcCtrl
  import serialCrcPkg::*;
#(
  parameter int WIDTH = CRC_W
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       serValid,
  input  logic       lastFrame,
  output crcStrobe_t strb,
  output logic       done
);
  localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WIDTH - 1);

  crcState_e state;
  logic [CNT_W-1:0] bitCnt;

  always_comb begin
    strb.absorb   = (state == ST_DATA) && serValid;
    strb.capture  = (state == ST_DATA) && serValid && lastFrame;
    strb.shiftOut = (state == ST_SHIFT);
    strb.finalBit = (state == ST_SHIFT) && (bitCnt == CNT_LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_DATA;
      bitCnt <= '0;
      done   <= 1'b0;
    end else begin
      done <= strb.finalBit;
      if (strb.capture) begin
        state  <= ST_SHIFT;
        bitCnt <= '0;
      end else if (strb.finalBit) begin
        state  <= ST_DATA;
        bitCnt <= '0;
      end else if (strb.shiftOut) begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/serialCrcDatapath.sv
module serialCrcDatapath
  import serialCrcPkg::*;
#(
  parameter int              WIDTH = CRC_W,
  parameter logic [WIDTH-1:0] POLY = CRC_POLY
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serIn,
  input  crcStrobe_t       strb,
  output logic             serOut,
  output logic             outValid,
  output logic [WIDTH-1:0] crcOut
);
  logic [WIDTH-1:0] crcReg;
  logic [WIDTH-1:0] crcNext;
  logic             feedback;

  assign feedback = serIn ^ crcReg[WIDTH-1];

  // One LFSR stage per register bit; the polynomial picks where feedback lands.
  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_stage
      if (gi == 0) begin : g_head
        assign crcNext[gi] = POLY[gi] & feedback;
      end else begin : g_body
        assign crcNext[gi] = crcReg[gi-1] ^ (POLY[gi] & feedback);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcReg   <= '0;
      crcOut   <= '0;
      serOut   <= 1'b0;
      outValid <= 1'b0;
    end else if (strb.shiftOut) begin
      // Shifting out with zero fill leaves the register clear after WIDTH bits.
      serOut   <= crcReg[WIDTH-1];
      outValid <= 1'b1;
      crcReg   <= {crcReg[WIDTH-2:0], 1'b0};
    end else if (strb.absorb) begin
      serOut   <= serIn;
      outValid <= 1'b1;
      crcReg   <= crcNext;
      if (strb.capture) crcOut <= crcNext;
    end else begin
      serOut   <= 1'b0;
      outValid <= 1'b0;
    end
  end
endmodule

// File: rtl/serialCrcGen.sv
module serialCrcGen
  import serialCrcPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              serIn,
  input  logic              serValid,
  input  logic              lastFrame,
  output logic              serOut,
  output logic              outValid,
  output logic              done,
  output logic [CRC_W-1:0]  crcOut
);
  crcStrobe_t strb;

  serialCrcCtrl #(.WIDTH(CRC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .serValid(serValid), .lastFrame(lastFrame),
    .strb(strb), .done(done)
  );

  serialCrcDatapath #(.WIDTH(CRC_W), .POLY(CRC_POLY)) u_dp (
    .clk(clk), .rstN(rstN), .serIn(serIn), .strb(strb),
    .serOut(serOut), .outValid(outValid), .crcOut(crcOut)
  );
endmodule

// File: rtl/serialCrcGenChecker.sv
module serialCrcGenChecker
  import serialCrcPkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             serIn,
  input logic             serValid,
  input logic             lastFrame,
  input logic             serOut,
  input logic             outValid,
  input logic             done,
  input logic [CRC_W-1:0] crcOut,
  input logic             shiftNow
);
  a_r3_echo: assert property (@(posedge clk) disable iff (!rstN)
    (serValid && !shiftNow) |=> (outValid && serOut == $past(serIn)));

  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!serValid && !shiftNow) |=> (!outValid && !serOut));

  a_r4_shift_valid: assert property (@(posedge clk) disable iff (!rstN)
    shiftNow |=> outValid);

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r6_done_with_bit: assert property (@(posedge clk) disable iff (!rstN)
    done |-> outValid);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(serValid && lastFrame && !shiftNow) |=> $stable(crcOut));

  a_r5_shift_ignores: assert property (@(posedge clk) disable iff (!rstN)
    shiftNow |=> $stable(crcOut));
endmodule

bind serialCrcGen serialCrcGenChecker u_chk (
  .clk(clk), .rstN(rstN), .serIn(serIn), .serValid(serValid),
  .lastFrame(lastFrame), .serOut(serOut), .outValid(outValid),
  .done(done), .crcOut(crcOut), .shiftNow(strb.shiftOut)
);

// File: tb/serialCrcGen_bench.sv
module serialCrcGen_bench;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serIn = 1'b0, serValid = 1'b0, lastFrame = 1'b0;
  logic serOut, outValid, done;
  logic [15:0] crcOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // behavioural model state
  logic [15:0] mCrc = '0, mHold = '0;
  bit mShift = 0;
  int mCnt = 0;
  bit expSer, expVal, expDone;

  bit curStream[$];
  bit outBits[$];

  always #(PERIOD/2) clk = ~clk;

  serialCrcGen u_serialCrcGen (
    .clk(clk), .rstN(rstN), .serIn(serIn), .serValid(serValid),
    .lastFrame(lastFrame), .serOut(serOut), .outValid(outValid),
    .done(done), .crcOut(crcOut)
  );

  function automatic logic [15:0] crcStep(logic [15:0] c, bit d);
    bit fb = d ^ c[15];
    return (c << 1) ^ (fb ? 16'h8005 : 16'h0000);
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit v, bit d, bit l);
    bit wasShift;
    serValid = v; serIn = d; lastFrame = l;
    @(posedge clk);
    wasShift = mShift;
    if (mShift) begin
      expSer = mHold[15 - mCnt]; expVal = 1; expDone = (mCnt == 15);
      mCnt++;
      if (mCnt == 16) begin mShift = 0; mCrc = '0; end
    end else if (v) begin
      expSer = d; expVal = 1; expDone = 0;
      mCrc = crcStep(mCrc, d);
      if (l) begin mHold = mCrc; mShift = 1; mCnt = 0; end
    end else begin
      expSer = 0; expVal = 0; expDone = 0;
    end
    #1;
    chk(outValid === expVal, wasShift ? "R4/R5 outValid" : "R3 outValid", 32'(outValid), 32'(expVal));
    chk(serOut === expSer, wasShift ? "R4/R5 serOut" : "R3 serOut", 32'(serOut), 32'(expSer));
    chk(done === expDone, "R6 done", 32'(done), 32'(expDone));
    chk(crcOut === mHold, "R2/R8 crcOut", 32'(crcOut), 32'(mHold));
    if (outValid) outBits.push_back(serOut);
  endtask

  // Sends curStream, then covers the checksum window and two idle cycles.
  task automatic runStream(bit noise, bit gaps);
    outBits.delete();
    foreach (curStream[i]) begin
      if (gaps && (i % 7 == 3)) step(0, 1'($urandom), 0);
      step(1, curStream[i], i == curStream.size() - 1);
    end
    for (int k = 0; k < 16; k++)
      step(noise, 1'($urandom), noise ? 1'($urandom) : 1'b0);
    step(0, 0, 0);
    step(0, 0, 0);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] firstCrc;
    logic [15:0] flipCrc;
    bit saved[$];
    int flipPos;
    #(PERIOD * 3 + 1);
    // R1: reset state
    chk(serOut === 0 && outValid === 0 && done === 0, "R1 outputs", {29'b0, serOut, outValid, done}, 0);
    chk(crcOut === 16'h0, "R1 crcOut", 32'(crcOut), 0);
    rstN = 1'b1;
    @(posedge clk); #1;

    // R2/R3/R4/R6: random stream with idle gaps
    for (int i = 0; i < 37; i++) curStream.push_back(1'($urandom));
    runStream(0, 1);
    firstCrc = crcOut;
    saved = outBits;

    // R9: replay data plus checksum, remainder zero
    curStream = saved;
    runStream(0, 0);
    chk(crcOut === 16'h0, "R9 residue", 32'(crcOut), 0);

    // R7: same data again gives same checksum
    curStream = saved[0:36];
    runStream(0, 0);
    chk(crcOut === firstCrc, "R7 repeat", 32'(crcOut), 32'(firstCrc));

    // R5: random valid inputs during the checksum window
    runStream(1, 0);
    chk(crcOut === firstCrc, "R5 noise ignored", 32'(crcOut), 32'(firstCrc));

    // single bit flipped: model comparison; a lone flip always changes this CRC
    flipPos = 11;
    curStream[flipPos] = ~curStream[flipPos];
    runStream(0, 0);
    flipCrc = crcOut;
    chk(flipCrc !== firstCrc, "R2 single flip", 32'(flipCrc), 32'(firstCrc));

    // boundary: one-bit stream
    curStream.delete();
    curStream.push_back(1'b1);
    runStream(0, 0);
    chk(crcOut === 16'h8005, "R2 one-bit stream", 32'(crcOut), 32'h8005);

    // several more random streams
    for (int s = 0; s < 5; s++) begin
      curStream.delete();
      for (int i = 0; i < 20 + s * 9; i++) curStream.push_back(1'($urandom));
      runStream(s[0], s[1]);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule